// File: doc/BRIEF.md
# Carrier-Based PWM Modulator with Deferred Parameter Update

This block is one channel of a carrier-based pulse-width modulator for a digital power-converter controller. A processor posts a compare level, a carrier start offset and a sampling-trigger position through a single-cycle write strobe. These values wait in a holding stage. They are applied to the working set only at defined carrier instants, so a switching period never runs with a half-updated set. The working set is never changed in the middle of a period.

The carrier is a counter with a programmable top value. It runs as a rising ramp, a falling ramp, a rising-first triangle or a falling-first triangle. The gate output is high while the effective carrier lies below the compare level. On triangle carriers, an optional mode also applies pending values at the carrier peak. A one-cycle converter-sampling strobe fires at a programmable position within the period. On triangle carriers a second strobe can be enabled half a period later, so that sampling keeps pace with the two updates per period.

Top module: `pwm_shadow_mod`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, `pwm_o` and `trig_o` are 0 and the counter sits at 0.
- R2: With `shape_i` = 0 (rising ramp) or 1 (falling ramp), the counter steps 0,1,…,P and then returns to its start value. The period is P+1 cycles, where P = `period_i`.
- R3: With `shape_i` = 2 (triangle) or 3 (inverted triangle), the counter rises 0…P and then falls P-1…1. The period is 2P cycles.
- R4: `pwm_o` is, one cycle late, high when the effective carrier is below the active level. The effective carrier is the counter when `shape_i` bit 0 is 0, and P minus the counter when it is 1.
- R5: An active level of 0 keeps `pwm_o` low for the whole period. An active level of P or more keeps it high for the whole period.
- R6: A write only updates the holding stage and sets a pending flag. The active set loads from the holding stage at a period start, and only if the flag is set. Without a new write, the active set keeps its values.
- R7: A write in the same cycle as a load edge does not take part in that load. It is applied at the next load edge.
- R8: With `dbl_upd_i` = 1 on a triangle carrier, a pending set is also loaded at the carrier peak. On a ramp carrier the flag has no effect.
- R9: At each period start the counter is preloaded with the active start offset, or with the pending one if a load happens at that edge. The offset must not exceed P.
- R10: `trig_o` pulses for one cycle, one cycle after the period position equals the active trigger position. The position is the counter on the rising part and 2P minus the counter on the falling part.
- R11: With `dbl_trig_i` = 1 on a triangle carrier, `trig_o` also pulses when the position equals the trigger position plus P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Carrier top value P (static, at least 2) |
| shape_i | input | 2 | 0 ramp, 1 falling ramp, 2 triangle, 3 inverted triangle |
| dbl_upd_i | input | 1 | Also load pending values at the triangle peak |
| dbl_trig_i | input | 1 | Second sampling strobe half a triangle period later |
| wr_valid_i | input | 1 | Write strobe for the holding stage |
| wr_duty_i | input | CNT_W | Compare level to post |
| wr_phase_i | input | CNT_W | Carrier start offset to post |
| wr_trig_i | input | CNT_W+1 | Sampling-trigger position to post |
| pwm_o | output | 1 | Gate output, registered |
| trig_o | output | 1 | Sampling strobe, registered |

## Verification
The collision that matters is a processor write landing in the very cycle whose edge loads the active set. The bench provokes it by watching its own period model and raising the strobe exactly when the model sits on the last count of a period. The test is repeated at the triangle peak with double update enabled. The result is judged at the outputs. The old compare level must persist for the whole next period, and the new one must appear only after the following load edge, which the per-cycle model comparison of `pwm_o` and `trig_o` exposes.

// File: rtl/pwm_cb_pkg.sv
package pwm_cb_pkg;
  typedef enum logic [1:0] {
    SHP_RAMP     = 2'd0,
    SHP_RAMP_INV = 2'd1,
    SHP_TRI      = 2'd2,
    SHP_TRI_INV  = 2'd3
  } shape_e;

  function automatic logic shape_is_tri(input logic [1:0] s);
    return s[1];
  endfunction

  function automatic logic shape_is_inv(input logic [1:0] s);
    return s[0];
  endfunction
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tri_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             start_o,
  output logic             peak_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  always_comb begin
    start_o = tri_i ? (!up_q && cnt_q == CNT_W'(1)) : (cnt_q >= period_i);
    peak_o  = tri_i && up_q && (cnt_q >= period_i);
    cnt_d   = cnt_q;
    up_d    = up_q;
    if (start_o) begin
      cnt_d = load_val_i;
      up_d  = 1'b1;
    end else if (peak_o) begin
      cnt_d = period_i - CNT_W'(1);
      up_d  = 1'b0;
    end else if (!tri_i || up_q) begin
      cnt_d = cnt_q + CNT_W'(1);
      up_d  = 1'b1;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;

  a_r3_turn_at_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_i && up_q && cnt_q == period_i) |=> !up_q);
  a_r9_ramp_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!tri_i && cnt_q == period_i) |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CNT_W = 8,
  localparam int IDX_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid_i,
  input  logic [CNT_W-1:0] wr_duty_i,
  input  logic [CNT_W-1:0] wr_phase_i,
  input  logic [IDX_W-1:0] wr_trig_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] duty_o,
  output logic [CNT_W-1:0] phase_o,
  output logic [IDX_W-1:0] trig_o,
  output logic [CNT_W-1:0] load_val_o
);
  logic [CNT_W-1:0] hold_duty_q, hold_phase_q, act_duty_q, act_phase_q;
  logic [IDX_W-1:0] hold_trig_q, act_trig_q;
  logic             pend_q, pend_d, take;

  always_comb begin
    take   = load_i && pend_q;
    pend_d = wr_valid_i | (pend_q & ~load_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_duty_q  <= '0;
      hold_phase_q <= '0;
      hold_trig_q  <= '0;
      pend_q       <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (wr_valid_i) begin
        hold_duty_q  <= wr_duty_i;
        hold_phase_q <= wr_phase_i;
        hold_trig_q  <= wr_trig_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_duty_q  <= '0;
      act_phase_q <= '0;
      act_trig_q  <= '0;
    end else if (take) begin
      act_duty_q  <= hold_duty_q;
      act_phase_q <= hold_phase_q;
      act_trig_q  <= hold_trig_q;
    end
  end

  assign duty_o     = act_duty_q;
  assign phase_o    = act_phase_q;
  assign trig_o     = act_trig_q;
  assign load_val_o = pend_q ? hold_phase_q : act_phase_q;

  a_r6_change_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_duty_q) |-> $past(load_i));
  a_r6_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !wr_valid_i) |=> !pend_q);
  a_r7_late_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && wr_valid_i) |=> pend_q);
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 8,
  localparam int IDX_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tri_i,
  input  logic             inv_i,
  input  logic             dbl_trig_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [IDX_W-1:0] trig_pos_i,
  output logic             pwm_o,
  output logic             trig_o
);
  logic [CNT_W-1:0] carrier;
  logic [IDX_W-1:0] pos, second_pos;
  logic             pwm_d, trig_d, pwm_q, trig_q;

  always_comb begin
    carrier    = inv_i ? (period_i - cnt_i) : cnt_i;
    pwm_d      = (duty_i >= period_i) || (carrier < duty_i);
    pos        = (up_i || !tri_i) ? {1'b0, cnt_i} : ({period_i, 1'b0} - {1'b0, cnt_i});
    second_pos = trig_pos_i + {1'b0, period_i};
    trig_d     = (pos == trig_pos_i) || (tri_i && dbl_trig_i && pos == second_pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      pwm_q  <= pwm_d;
      trig_q <= trig_d;
    end
  end

  assign pwm_o  = pwm_q;
  assign trig_o = trig_q;

  a_r5_zero_level_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |=> !pwm_q);
  a_r5_full_level_high: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i >= period_i) |=> pwm_q);
endmodule

// File: rtl/pwm_shadow_mod.sv
module pwm_shadow_mod #(
  parameter int CNT_W = 8,
  localparam int IDX_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [1:0]       shape_i,
  input  logic             dbl_upd_i,
  input  logic             dbl_trig_i,
  input  logic             wr_valid_i,
  input  logic [CNT_W-1:0] wr_duty_i,
  input  logic [CNT_W-1:0] wr_phase_i,
  input  logic [IDX_W-1:0] wr_trig_i,
  output logic             pwm_o,
  output logic             trig_o
);
  import pwm_cb_pkg::*;

  logic             is_tri, is_inv, start, peak, load, up;
  logic [CNT_W-1:0] cnt, duty_act, phase_act, load_val;
  logic [IDX_W-1:0] trig_act;

  assign is_tri = shape_is_tri(shape_i);
  assign is_inv = shape_is_inv(shape_i);
  assign load   = start | (peak & dbl_upd_i);

  pwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst_n(rst_n), .tri_i(is_tri), .period_i(period_i),
    .load_val_i(load_val), .cnt_o(cnt), .up_o(up), .start_o(start), .peak_o(peak)
  );

  pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_duty_i(wr_duty_i),
    .wr_phase_i(wr_phase_i), .wr_trig_i(wr_trig_i), .load_i(load),
    .duty_o(duty_act), .phase_o(phase_act), .trig_o(trig_act), .load_val_o(load_val)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_compare (
    .clk(clk), .rst_n(rst_n), .tri_i(is_tri), .inv_i(is_inv), .dbl_trig_i(dbl_trig_i),
    .period_i(period_i), .cnt_i(cnt), .up_i(up), .duty_i(duty_act),
    .trig_pos_i(trig_act), .pwm_o(pwm_o), .trig_o(trig_o)
  );

  a_r8_ramp_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_tri && !$stable(duty_act)) |-> $past(cnt >= period_i));
  a_r2_ramp_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_tri && $past(!is_tri) && $past(phase_act <= period_i) && $past(load_val <= period_i)
     && $past(cnt <= period_i)) |-> (cnt <= period_i));
endmodule

// File: tb/pwm_shadow_mod_bench.sv
module pwm_shadow_mod_bench;
  localparam int W = 8;
  localparam int P = 10;

  typedef struct packed {
    logic [1:0] shp;
    logic       du;
    logic       dt;
    logic [7:0] d;
    logic [7:0] p;
    logic [8:0] t;
  } scn_t;

  localparam scn_t SCN [8] = '{
    '{2'd0, 1'b0, 1'b0, 8'd4,  8'd0, 9'd5},
    '{2'd1, 1'b0, 1'b0, 8'd3,  8'd2, 9'd0},
    '{2'd2, 1'b0, 1'b0, 8'd6,  8'd0, 9'd10},
    '{2'd3, 1'b0, 1'b1, 8'd7,  8'd3, 9'd0},
    '{2'd2, 1'b1, 1'b1, 8'd5,  8'd0, 9'd2},
    '{2'd0, 1'b0, 1'b0, 8'd0,  8'd0, 9'd3},
    '{2'd2, 1'b0, 1'b0, 8'd10, 8'd0, 9'd4},
    '{2'd0, 1'b1, 1'b1, 8'd15, 8'd0, 9'd9}
  };

  function automatic string scn_tag(input int i);
    case (i)
      0: return "R2";
      1: return "R4 R9";
      2: return "R3";
      3: return "R11 R9";
      4: return "R8";
      5, 6: return "R5";
      default: return "R8 R5";
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] shape = '0;
  logic du = 1'b0, dt = 1'b0, wv = 1'b0;
  logic [W-1:0] wd = '0, wp = '0;
  logic [W:0] wt = '0;
  logic pwm_o, trig_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_shadow_mod #(.CNT_W(W)) u_pwm_shadow_mod (
    .clk(clk), .rst_n(rst_n), .period_i(W'(P)), .shape_i(shape), .dbl_upd_i(du),
    .dbl_trig_i(dt), .wr_valid_i(wv), .wr_duty_i(wd), .wr_phase_i(wp), .wr_trig_i(wt),
    .pwm_o(pwm_o), .trig_o(trig_o)
  );

  int m_pos, m_d, m_p, m_t, s_d, s_p, s_t;
  bit m_pend, e_pwm, e_trig;

  always @(posedge clk or negedge rst_n) begin : model
    int len, c, ce;
    bit tri_m, ld;
    if (!rst_n) begin
      m_pos <= 0; m_d <= 0; m_p <= 0; m_t <= 0;
      s_d <= 0; s_p <= 0; s_t <= 0; m_pend <= 0;
      e_pwm <= 0; e_trig <= 0;
    end else begin
      tri_m = shape[1];
      len = tri_m ? 2 * P : P + 1;
      c = (m_pos <= P) ? m_pos : 2 * P - m_pos;
      ce = shape[0] ? P - c : c;
      e_pwm <= (m_d >= P) || (ce < m_d);
      e_trig <= (m_pos == m_t) || (tri_m && dt && m_pos == m_t + P);
      ld = (m_pos == len - 1) || (tri_m && du && m_pos == P);
      if (m_pos == len - 1) m_pos <= m_pend ? s_p : m_p;
      else m_pos <= m_pos + 1;
      if (ld && m_pend) begin m_d <= s_d; m_p <= s_p; m_t <= s_t; end
      if (wv) begin s_d <= wd; s_p <= wp; s_t <= wt; m_pend <= 1; end
      else if (ld) m_pend <= 0;
    end
  end

  task automatic check(input string tag, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, pwm_o, e_pwm, "pwm_o");
      check("R10", trig_o, e_trig, "trig_o");
    end
  endtask

  task automatic post(input int d, input int p, input int t, input string tag);
    wd = W'(d); wp = W'(p); wt = (W+1)'(t); wv = 1'b1;
    run(1, tag);
    wv = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", pwm_o, 1'b0, "pwm_o in reset");
    check("R1", trig_o, 1'b0, "trig_o in reset");
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    run(1, "R1");
    for (int i = 0; i < 8; i++) begin
      shape = SCN[i].shp; du = SCN[i].du; dt = SCN[i].dt;
      do_reset();
      post(SCN[i].d, SCN[i].p, SCN[i].t, scn_tag(i));
      run(70, scn_tag(i));
    end
    // R6: mid-period write must wait for the next period start
    shape = 2'd2; du = 1'b0; dt = 1'b0;
    do_reset();
    post(4, 0, 0, "R6");
    run(25, "R6");
    post(8, 0, 3, "R6");
    run(45, "R6");
    // R7: write on the load edge itself is deferred by one period
    while (m_pos != 2 * P - 1) run(1, "R7");
    post(2, 0, 6, "R7");
    run(45, "R7");
    // R7 with double update: write on the peak edge
    du = 1'b1;
    while (m_pos != P) run(1, "R7");
    post(9, 1, 1, "R7");
    run(50, "R8");
    finish_run();
  end
endmodule